// File: doc/BRIEF.md
# Four-Phase Self-Timed Bus Write Master

This block issues single write transfers on a bus that has no clock. A local command port hands it an address, a data word and a one-cycle start pulse. The master captures the command and drives address, data and the write direction onto the bus at the same time. It then waits a programmable number of local clocks so that every slave can decode the target. After that wait it paces the rest of the transfer only by request and acknowledge edges.

The handshake has four phases. The master raises request, and the slave raises acknowledge. The master sees acknowledge and drops request, and the slave then drops acknowledge. The acknowledge input is asynchronous to the master, so it passes through a two-flop synchroniser before the controller uses it. If acknowledge does not rise within a programmable number of clocks, the master withdraws request, raises a sticky error flag and goes back to idle. A successful transfer ends with a one-clock completion pulse.

The controller has four named states. IDLE waits for a command. SETTLE holds the bus steady during the decode wait. ASK holds request high and waits for acknowledge. RELEASE has request low and waits for acknowledge to fall. The transitions are as follows. IDLE goes to SETTLE on an accepted start. SETTLE goes to ASK when the settle count is spent and the synchronised acknowledge is low. ASK goes to RELEASE when the synchronised acknowledge is high. ASK goes to IDLE on abort when the timeout count is spent. RELEASE goes to IDLE on completion when the synchronised acknowledge is low.

Top module: `async_write_master`

## Requirements
- R1: While reset is asserted and right after it, bus_req, bus_wr, busy, done and err are all 0.
- R2: On the clock edge that samples cmd_start high in idle, bus_addr and bus_data take the command values and bus_wr and busy go to 1. All of these are visible after that same edge.
- R3: bus_req rises exactly cfg_settle+1 clocks after the edge that accepted the start, provided the acknowledge input is low. Request never rises while the synchronised acknowledge is high.
- R4: bus_req stays high until acknowledge is seen. It falls after the third rising clock edge that follows acknowledge going high, which allows two edges of synchroniser delay and one edge for the state change.
- R5: After acknowledge falls, done is 1 for exactly one clock, starting after the third rising edge. bus_req is 0 by then and busy falls together with the done pulse.
- R6: bus_addr, bus_data and bus_wr (held at 1) do not change from the accepting edge until the transfer ends.
- R7: A cmd_start while busy is 1 is ignored. The bus address stays at the value of the accepted command, and no second transfer starts after the first one ends.
- R8: If acknowledge stays low, bus_req falls after cfg_timeout+1 clocks high. err then becomes 1, busy becomes 0 and done stays 0.
- R9: err stays 1 until the next accepted start and reads 0 right after that start's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | One-cycle request to begin a write |
| cmd_addr | input | ADDR_W | Target address for the write |
| cmd_data | input | DATA_W | Write data |
| cfg_settle | input | SETTLE_W | Decode wait in clocks (the actual wait is this value plus 1) |
| cfg_timeout | input | TMO_W | Acknowledge wait limit in clocks (the actual limit is this value plus 1) |
| bus_addr | output | ADDR_W | Address driven on the bus |
| bus_data | output | DATA_W | Data driven on the bus |
| bus_wr | output | 1 | Direction line, 1 means write |
| bus_req | output | 1 | Handshake request |
| bus_ack | input | 1 | Handshake acknowledge from the slave (asynchronous) |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-clock pulse when a transfer completes |
| err | output | 1 | Sticky flag set when a transfer is aborted on timeout |

## Verification
Some properties are checked on every cycle by the embedded properties. These are that the bus stays stable during a transfer, that request stays low when the master is not busy, that request only rises while the synchronised acknowledge is low and only falls on acknowledge or abort, that done lasts one clock and comes after the handshake is over, and that an abort never pulses done. Other behaviour can only be shown by the bench scenarios. This covers the exact clock counts from start to request, from acknowledge to request release and from release to done, as well as the timeout length and the clearing of err on the next command. It also covers ignored starts, which are checked by watching the bus and the idle period afterwards, and slave response delays that vary at random.

// File: rtl/awm_pkg.sv
package awm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETTLE  = 2'd1,
        ST_ASK     = 2'd2,
        ST_RELEASE = 2'd3
    } awm_state_e;
endpackage

// File: rtl/awm_sync.sv
module awm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/awm_timer.sv
module awm_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (load)             cnt_q <= load_val;
        else if (dec && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/async_write_master.sv
module async_write_master #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 32,
    parameter int SETTLE_W    = 8,
    parameter int TMO_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_start,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic [DATA_W-1:0]   cmd_data,
    input  logic [SETTLE_W-1:0] cfg_settle,
    input  logic [TMO_W-1:0]    cfg_timeout,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [DATA_W-1:0]   bus_data,
    output logic                bus_wr,
    output logic                bus_req,
    input  logic                bus_ack,
    output logic                busy,
    output logic                done,
    output logic                err
);
    import awm_pkg::*;

    localparam int CNT_W = (SETTLE_W > TMO_W) ? SETTLE_W : TMO_W;

    awm_state_e       st_q, st_nx;
    logic             ack_s;
    logic             tmr_load, tmr_dec, tmr_expired;
    logic [CNT_W-1:0] tmr_val;
    logic             accept, finish, abort;

    awm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (bus_ack),
        .sync_out (ack_s)
    );

    awm_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .dec      (tmr_dec),
        .expired  (tmr_expired)
    );

    // next-state and timer control
    always_comb begin
        st_nx    = st_q;
        tmr_load = 1'b0;
        tmr_dec  = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        finish   = 1'b0;
        abort    = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (cmd_start) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(cfg_settle);
                    st_nx    = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (tmr_expired && !ack_s) begin
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(cfg_timeout);
                    st_nx    = ST_ASK;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_ASK: begin
                if (ack_s) begin
                    st_nx = ST_RELEASE;
                end else if (tmr_expired) begin
                    abort = 1'b1;
                    st_nx = ST_IDLE;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_RELEASE: begin
                if (!ack_s) begin
                    finish = 1'b1;
                    st_nx  = ST_IDLE;
                end
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    // registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_addr <= '0;
            bus_data <= '0;
            bus_wr   <= 1'b0;
            bus_req  <= 1'b0;
            busy     <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            if (accept) begin
                bus_addr <= cmd_addr;
                bus_data <= cmd_data;
            end
            bus_wr  <= (st_nx != ST_IDLE);
            bus_req <= (st_nx == ST_ASK);
            busy    <= (st_nx != ST_IDLE);
            done    <= finish;
            if (accept)     err <= 1'b0;
            else if (abort) err <= 1'b1;
        end
    end

    // bus held steady for the whole transfer
    p_bus_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(bus_addr) && $stable(bus_data) && bus_wr));

    // no request outside a transfer
    p_req_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);

    // request rises only with acknowledge low
    p_req_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> (!ack_s && busy));

    // request falls only on acknowledge or abort
    p_req_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> (ack_s || err));

    // single-cycle completion after the handshake is over
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!bus_req && !ack_s && !busy));

    // abort never reports completion
    p_abort_no_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> (!done && !busy));
endmodule

// File: tb/sim_async_write_master.sv
module sim_async_write_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [15:0] cmd_addr = '0;
    logic [31:0] cmd_data = '0;
    logic [7:0]  cfg_settle = '0;
    logic [15:0] cfg_timeout = 16'd200;
    logic [15:0] bus_addr;
    logic [31:0] bus_data;
    logic        bus_wr, bus_req, busy, done, err;
    logic        bus_ack = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    async_write_master u0 (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .cfg_settle(cfg_settle), .cfg_timeout(cfg_timeout),
        .bus_addr(bus_addr), .bus_data(bus_data), .bus_wr(bus_wr),
        .bus_req(bus_req), .bus_ack(bus_ack), .busy(busy), .done(done), .err(err)
    );

    // addr, data, settle, ack-rise delay, ack-fall delay
    localparam int NV = 6;
    localparam logic [71:0] VEC [NV] = '{
        {16'h1234, 32'hDEADBEEF, 8'd0,  8'd0,  8'd0},
        {16'hABCD, 32'h00000001, 8'd1,  8'd2,  8'd1},
        {16'h0000, 32'hFFFFFFFF, 8'd3,  8'd5,  8'd4},
        {16'hFFFF, 32'h5A5A5A5A, 8'd7,  8'd1,  8'd9},
        {16'h8001, 32'h80000001, 8'd15, 8'd12, 8'd0},
        {16'h4242, 32'h13579BDF, 8'd2,  8'd20, 8'd20}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [15:0] a, input logic [31:0] d, input int s,
                        input int dh, input int dl, input bit poke);
        int k;
        int m;
        cfg_settle = 8'(s);
        cmd_addr = a;
        cmd_data = d;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        chk(busy == 1'b1 && bus_wr == 1'b1, "R2 busy/wr", {busy, bus_wr}, 2'b11);
        chk(bus_addr == a && bus_data == d, "R2 bus values", {bus_addr, bus_data}, {a, d});
        chk(err == 1'b0, "R9 err cleared", err, 0);
        k = 0;
        while (!bus_req && k < 400) begin
            if (poke && k == 1) begin
                cmd_start = 1'b1;
                cmd_addr = ~a;
            end else begin
                cmd_start = 1'b0;
            end
            @(negedge clk);
            k++;
            if (bus_addr !== a) chk(1'b0, "R6/R7 addr held", bus_addr, a);
        end
        cmd_start = 1'b0;
        chk(k == s + 1, "R3 settle length", k, s + 1);
        repeat (dh) @(negedge clk);
        chk(bus_req == 1'b1 && busy == 1'b1, "R4 req held", bus_req, 1);
        bus_ack = 1'b1;
        m = 0;
        while (bus_req && m < 50) begin
            @(negedge clk);
            m++;
        end
        chk(m == 3, "R4 req release delay", m, 3);
        repeat (dl) @(negedge clk);
        chk(!done && !bus_req && busy, "R5 waiting for ack fall", {done, bus_req, busy}, 3'b001);
        chk(bus_addr == a && bus_data == d, "R6 bus stable", {bus_addr, bus_data}, {a, d});
        bus_ack = 1'b0;
        m = 0;
        while (!done && m < 50) begin
            @(negedge clk);
            m++;
        end
        chk(m == 3, "R5 done delay", m, 3);
        chk(busy == 1'b0, "R5 busy with done", busy, 0);
        @(negedge clk);
        chk(done == 1'b0, "R5 done one clock", done, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int j;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({bus_req, bus_wr, busy, done, err} == 5'b0, "R1 in reset",
            {bus_req, bus_wr, busy, done, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({bus_req, bus_wr, busy, done, err} == 5'b0, "R1 after reset",
            {bus_req, bus_wr, busy, done, err}, 0);

        // table walk with random slave delays
        for (int i = 0; i < NV; i++) begin
            xfer(VEC[i][71:56], VEC[i][55:24], int'(VEC[i][23:16]),
                 int'(VEC[i][15:8]) + int'($urandom_range(0, 3)),
                 int'(VEC[i][7:0]) + int'($urandom_range(0, 3)), 1'b0);
            repeat (2) @(negedge clk);
        end

        // R7: start during a transfer is ignored
        xfer(16'h00F0, 32'hCAFEF00D, 6, 2, 2, 1'b1);
        j = 0;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            if (busy || bus_req) j++;
        end
        chk(j == 0, "R7 no second transfer", j, 0);
        chk(bus_addr == 16'h00F0, "R7 addr kept", bus_addr, 16'h00F0);

        // R8: timeout with no acknowledge
        cfg_timeout = 16'd5;
        cfg_settle = 8'd2;
        cmd_addr = 16'h7777;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        j = 0;
        while (!bus_req && j < 50) begin
            @(negedge clk);
            j++;
        end
        chk(j == 3, "R8 req rises before timeout", j, 3);
        j = 0;
        while (bus_req && j < 50) begin
            @(negedge clk);
            j++;
            if (done) chk(1'b0, "R8 no done on abort", done, 0);
        end
        chk(j == 6, "R8 timeout length", j, 6);
        chk(err == 1'b1 && busy == 1'b0 && done == 1'b0, "R8 err set",
            {err, busy, done}, 3'b100);
        repeat (4) @(negedge clk);
        chk(err == 1'b1 && bus_req == 1'b0, "R9 err sticky", {err, bus_req}, 2'b10);

        // R9: next command clears err and runs normally
        cfg_timeout = 16'd200;
        xfer(16'h2468, 32'h0BADF00D, 1, 3, 1, 1'b0);
        chk(err == 1'b0, "R9 err after good transfer", err, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule